// File: doc/BRIEF.md
# Maskable Calendar Alarm Comparator

This block sits beside a calendar timekeeper and watches its BCD outputs (seconds, minutes, hours with a PM indicator, day of month and weekday). Software programs a 32-bit alarm word; on every calendar second update the block compares the current time with that word. Any of the four fields can be taken out of the comparison by its own mask bit. The day field is matched either as a day of month or as a weekday, depending on a select bit.

A match while the alarm is enabled sets a sticky alarm flag. The interrupt output is that flag gated by an interrupt enable. The alarm word is protected by a handshake. Software first clears the alarm enable. A short, fixed number of clock cycles later the block raises a write-allowed indication, and only then does it accept a new alarm word. The flag is cleared through a status write. A build parameter chooses one of two conventions: writing 0 to the flag's position, or writing 1 to a clear bit.

Top module: `cal_alarm_unit`

## Requirements
- R1: After reset the alarm word reads 0, alarm enable and interrupt enable are 0, the flag and irq are 0, and wr_allowed is 1.
- R2: With all masks clear, a match needs every field to be equal: seconds (word bits 6:0), minutes (14:8), hours (21:16) and the day field.
- R3: A mask bit at 1 removes its field from the comparison: bit 7 for seconds, bit 15 for minutes, bit 23 for hours, bit 31 for the day.
- R4: With word bit 30 at 1, the day field compares bits 27:24 with the weekday. With bit 30 at 0, it compares bits 29:24 with the day of month.
- R5: The PM bit (word bit 22) must equal cur_pm only when hour12 is 1. When hour12 is 0 it is ignored.
- R6: The flag is set only on a clock where tick is 1, the alarm is enabled and the time matches. Enabling the alarm, or a match without tick, never sets it.
- R7: Control-word bit 8 is the alarm enable and bit 12 is the interrupt enable. irq is 1 exactly when the flag and the interrupt enable are both 1.
- R8: wr_allowed falls on the clock edge that sets the alarm enable. It rises WAF_DELAY clock edges after the edge that clears the enable.
- R9: An alarm-word write made while wr_allowed is 0 is ignored. A write made while it is 1 is stored.
- R10: With CLEAR_BY_ONE=0, a status write with bit 8 at 0 clears the flag and one with bit 8 at 1 leaves it. With CLEAR_BY_ONE=1, writing 1 to bit 0 clears it. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hour12 | input | 1 | Calendar runs in 12-hour format |
| tick | input | 1 | One-cycle strobe at each calendar second update |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD |
| cur_pm | input | 1 | Current PM indicator |
| cur_date | input | 6 | Current day of month, BCD |
| cur_wday | input | 3 | Current weekday, 1 to 7 |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word data |
| alm_we | input | 1 | Alarm word write strobe |
| alm_wdata | input | 32 | Alarm word data |
| st_we | input | 1 | Status or clear register write strobe |
| st_wdata | input | 32 | Status or clear register data |
| alarm_word | output | 32 | Stored alarm word |
| alarm_en | output | 1 | Alarm enable |
| irq_en | output | 1 | Interrupt enable |
| wr_allowed | output | 1 | Alarm word may be written |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq | output | 1 | Alarm interrupt |

## Verification
A wrong comparator term shows up on alarm_flag at the first tick whose calendar values exercise that field or mask. It is visible one clock after the tick, and so are the flag clear and set-over-clear cases. A corrupted write-allowed counter becomes visible as an early or late rise of wr_allowed within WAF_DELAY clocks of a disable. It also shows as an alarm_word readback that changes, or fails to change, after a write. Because a reference model is compared on every clock, any divergence in enable, flag or irq is reported in the cycle it appears.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int unsigned WORD_W   = 32;
  // alarm word field positions (decoded by the comparator)
  localparam int unsigned SEC_LSB  = 0;
  localparam int unsigned SEC_W    = 7;
  localparam int unsigned SEC_IGN  = 7;
  localparam int unsigned MIN_LSB  = 8;
  localparam int unsigned MIN_W    = 7;
  localparam int unsigned MIN_IGN  = 15;
  localparam int unsigned HR_LSB   = 16;
  localparam int unsigned HR_W     = 6;
  localparam int unsigned HR_PM    = 22;
  localparam int unsigned HR_IGN   = 23;
  localparam int unsigned DAY_LSB  = 24;
  localparam int unsigned DATE_W   = 6;
  localparam int unsigned WDAY_W   = 4;
  localparam int unsigned DAY_WSEL = 30;
  localparam int unsigned DAY_IGN  = 31;
  // control and status bit positions
  localparam int unsigned CTL_EN   = 8;
  localparam int unsigned CTL_IE   = 12;
  localparam int unsigned ST_FLAG  = 8;
  localparam int unsigned CLR_FLAG = 0;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;
    logic       pm;
    logic [5:0] date;
    logic [2:0] wday;
  } cal_now_t;
endpackage

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  cal_now_t          now,
  input  logic              hour12,
  output logic              hit
);
  logic sec_ok, min_ok, pm_ok, hr_ok, date_eq, wday_eq, day_ok;

  always_comb begin
    sec_ok  = word[SEC_IGN] | (now.sec == word[SEC_LSB +: SEC_W]);
    min_ok  = word[MIN_IGN] | (now.min == word[MIN_LSB +: MIN_W]);
    pm_ok   = ~hour12 | (now.pm == word[HR_PM]);
    hr_ok   = word[HR_IGN] | ((now.hour == word[HR_LSB +: HR_W]) & pm_ok);
    date_eq = (now.date == word[DAY_LSB +: DATE_W]);
    wday_eq = ({1'b0, now.wday} == word[DAY_LSB +: WDAY_W]);
    day_ok  = word[DAY_IGN] | (word[DAY_WSEL] ? wday_eq : date_eq);
    hit     = sec_ok & min_ok & hr_ok & day_ok;
  end
endmodule

// File: rtl/cal_alarm_wgate.sv
module cal_alarm_wgate #(
  parameter int unsigned DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_q,
  input  logic en_next,
  output logic waf
);
  localparam int unsigned CW = (DELAY < 2) ? 1 : $clog2(DELAY);
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          waf_q, waf_d;

  always_comb begin
    cnt_d = cnt_q;
    waf_d = waf_q;
    if (en_next) begin
      waf_d = 1'b0;
      cnt_d = '0;
    end else if (en_q) begin
      cnt_d = '0;
    end else if (!waf_q) begin
      if (cnt_q == LAST) waf_d = 1'b1;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      waf_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      waf_q <= waf_d;
    end
  end

  assign waf = waf_q;
endmodule

// File: rtl/cal_alarm_flag.sv
module cal_alarm_flag
  import cal_alarm_pkg::*;
#(
  parameter bit CLEAR_BY_ONE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set,
  input  logic              st_we,
  input  logic [WORD_W-1:0] st_wdata,
  output logic              flag
);
  logic clr, flag_q, flag_d;

  generate
    if (CLEAR_BY_ONE) begin : g_w1c
      assign clr = st_we & st_wdata[CLR_FLAG];
    end else begin : g_w0c
      assign clr = st_we & ~st_wdata[ST_FLAG];
    end
  endgenerate

  always_comb begin
    flag_d = flag_q;
    if (set)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/cal_alarm_unit.sv
module cal_alarm_unit
  import cal_alarm_pkg::*;
#(
  parameter int unsigned WAF_DELAY    = 2,
  parameter bit          CLEAR_BY_ONE = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hour12,
  input  logic        tick,
  input  logic [6:0]  cur_sec,
  input  logic [6:0]  cur_min,
  input  logic [5:0]  cur_hour,
  input  logic        cur_pm,
  input  logic [5:0]  cur_date,
  input  logic [2:0]  cur_wday,
  input  logic        ctl_we,
  input  logic [31:0] ctl_wdata,
  input  logic        alm_we,
  input  logic [31:0] alm_wdata,
  input  logic        st_we,
  input  logic [31:0] st_wdata,
  output logic [31:0] alarm_word,
  output logic        alarm_en,
  output logic        irq_en,
  output logic        wr_allowed,
  output logic        alarm_flag,
  output logic        irq
);
  logic              en_q, en_d, ie_q, ie_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              waf, hit, set;
  cal_now_t          now;

  assign now = '{sec: cur_sec, min: cur_min, hour: cur_hour, pm: cur_pm,
                 date: cur_date, wday: cur_wday};

  always_comb begin
    en_d   = en_q;
    ie_d   = ie_q;
    word_d = word_q;
    if (ctl_we) begin
      en_d = ctl_wdata[CTL_EN];
      ie_d = ctl_wdata[CTL_IE];
    end
    if (alm_we && waf) word_d = alm_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      word_q <= '0;
    end else begin
      en_q   <= en_d;
      ie_q   <= ie_d;
      word_q <= word_d;
    end
  end

  cal_alarm_match u_match (
    .word   (word_q),
    .now    (now),
    .hour12 (hour12),
    .hit    (hit)
  );

  cal_alarm_wgate #(.DELAY(WAF_DELAY)) u_wgate (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_q    (en_q),
    .en_next (en_d),
    .waf     (waf)
  );

  assign set = tick & en_q & hit;

  cal_alarm_flag #(.CLEAR_BY_ONE(CLEAR_BY_ONE)) u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (set),
    .st_we    (st_we),
    .st_wdata (st_wdata),
    .flag     (alarm_flag)
  );

  assign alarm_word = word_q;
  assign alarm_en   = en_q;
  assign irq_en     = ie_q;
  assign wr_allowed = waf;
  assign irq        = alarm_flag & ie_q;
endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        st_we,
  input logic        alm_we,
  input logic [31:0] alarm_word,
  input logic        alarm_en,
  input logic        wr_allowed,
  input logic        alarm_flag,
  input logic        irq
);
  p_flag_needs_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(tick && alarm_en));

  p_word_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_allowed) |=> (alarm_word == $past(alarm_word)));

  p_word_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!alm_we) |=> (alarm_word == $past(alarm_word)));

  p_waf_low_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_en |-> !wr_allowed);

  p_waf_rise_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_allowed) |-> !alarm_en);

  p_no_irq_without_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_flag) |-> !irq);

  p_clear_needs_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm_flag) |-> $past(st_we));
endmodule

bind cal_alarm_unit cal_alarm_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .st_we      (st_we),
  .alm_we     (alm_we),
  .alarm_word (alarm_word),
  .alarm_en   (alarm_en),
  .wr_allowed (wr_allowed),
  .alarm_flag (alarm_flag),
  .irq        (irq)
);

// File: tb/cal_alarm_unit_tb.sv
module cal_alarm_unit_tb;
  localparam int DLY = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hour12 = 1'b0, tick = 1'b0, cur_pm = 1'b0;
  logic [6:0]  cur_sec = '0, cur_min = '0;
  logic [5:0]  cur_hour = '0, cur_date = '0;
  logic [2:0]  cur_wday = '0;
  logic        ctl_we = 1'b0, alm_we = 1'b0, st_we = 1'b0;
  logic [31:0] ctl_wdata = '0, alm_wdata = '0, st_wdata = '0;
  logic [31:0] alarm_word;
  logic        alarm_en, irq_en, wr_allowed, alarm_flag, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cal_alarm_unit #(.WAF_DELAY(DLY), .CLEAR_BY_ONE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .hour12(hour12), .tick(tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_pm(cur_pm),
    .cur_date(cur_date), .cur_wday(cur_wday),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .alm_we(alm_we), .alm_wdata(alm_wdata),
    .st_we(st_we), .st_wdata(st_wdata),
    .alarm_word(alarm_word), .alarm_en(alarm_en), .irq_en(irq_en),
    .wr_allowed(wr_allowed), .alarm_flag(alarm_flag), .irq(irq)
  );

  // ---------------- reference model ----------------
  int          m_en, m_ie, m_flag, m_waf, m_since;
  logic [31:0] m_word;

  function automatic bit ref_match(logic [31:0] w);
    int s_ok, mi_ok, h_ok, d_ok;
    s_ok  = (w >> 7) & 1 ? 1 : (cur_sec == ((w >> 0) & 32'h7f));
    mi_ok = (w >> 15) & 1 ? 1 : (cur_min == ((w >> 8) & 32'h7f));
    if ((w >> 23) & 1) h_ok = 1;
    else begin
      h_ok = (cur_hour == ((w >> 16) & 32'h3f));
      if (hour12 && (cur_pm != ((w >> 22) & 1))) h_ok = 0;
    end
    if ((w >> 31) & 1) d_ok = 1;
    else if ((w >> 30) & 1) d_ok = (cur_wday == ((w >> 24) & 32'hf));
    else d_ok = (cur_date == ((w >> 24) & 32'h3f));
    return (s_ok != 0) && (mi_ok != 0) && (h_ok != 0) && (d_ok != 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_ie = 0; m_flag = 0; m_waf = 1; m_since = 0; m_word = '0;
    end else begin
      int  en_n, set_e, clr_e;
      set_e = tick && (m_en != 0) && ref_match(m_word);
      clr_e = st_we && !st_wdata[8];
      if (alm_we && m_waf) m_word = alm_wdata;
      en_n = ctl_we ? ctl_wdata[8] : m_en;
      if (ctl_we) m_ie = ctl_wdata[12];
      if (en_n) begin m_waf = 0; m_since = 0; end
      else if (m_en) m_since = 0;
      else if (!m_waf) begin
        m_since++;
        if (m_since == DLY) m_waf = 1;
      end
      m_en = en_n;
      if (set_e) m_flag = 1;
      else if (clr_e) m_flag = 0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9 model alarm_word", alarm_word, m_word);
      chk("R7 model alarm_en", {31'b0, alarm_en}, m_en);
      chk("R7 model irq_en", {31'b0, irq_en}, m_ie);
      chk("R8 model wr_allowed", {31'b0, wr_allowed}, m_waf);
      chk("R6 model alarm_flag", {31'b0, alarm_flag}, m_flag);
      chk("R7 model irq", {31'b0, irq}, (m_flag && m_ie) ? 1 : 0);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr_ctl(logic [31:0] d);
    ctl_we = 1'b1; ctl_wdata = d; @(negedge clk); ctl_we = 1'b0;
  endtask
  task automatic wr_alm(logic [31:0] d);
    alm_we = 1'b1; alm_wdata = d; @(negedge clk); alm_we = 1'b0;
  endtask
  task automatic wr_st(logic [31:0] d);
    st_we = 1'b1; st_wdata = d; @(negedge clk); st_we = 1'b0;
  endtask
  task automatic do_tick();
    tick = 1'b1; @(negedge clk); tick = 1'b0;
  endtask
  task automatic set_now(logic [6:0] s, logic [6:0] m, logic [5:0] h, logic p,
                         logic [5:0] d, logic [2:0] w);
    cur_sec = s; cur_min = m; cur_hour = h; cur_pm = p; cur_date = d; cur_wday = w;
  endtask
  task automatic disable_and_wait();
    wr_ctl(32'h0);
    repeat (DLY + 1) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 word", alarm_word, 32'h0);
    chk("R1 en", {31'b0, alarm_en}, 0);
    chk("R1 ie", {31'b0, irq_en}, 0);
    chk("R1 flag", {31'b0, alarm_flag}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 waf", {31'b0, wr_allowed}, 1);

    // R9 write accepted while allowed
    wr_alm(32'h1208_1530);
    chk("R9 word stored", alarm_word, 32'h1208_1530);

    // R8 enable drops wr_allowed on the same edge
    wr_ctl(32'h0000_1100);
    chk("R8 waf low on enable", {31'b0, wr_allowed}, 0);
    chk("R7 enable bit", {31'b0, alarm_en}, 1);

    // R9 write ignored while not allowed
    wr_alm(32'hFFFF_FFFF);
    chk("R9 word unchanged", alarm_word, 32'h1208_1530);

    // R6 match without tick does nothing; R2 full match on tick
    set_now(7'h30, 7'h15, 6'h08, 1'b0, 6'h12, 3'd2);
    @(negedge clk);
    chk("R6 no tick no flag", {31'b0, alarm_flag}, 0);
    do_tick();
    chk("R2 full match flag", {31'b0, alarm_flag}, 1);
    chk("R7 irq asserted", {31'b0, irq}, 1);

    // R10 clear semantics
    wr_st(32'h0000_0100);
    chk("R10 write 1 keeps flag", {31'b0, alarm_flag}, 1);
    wr_st(32'h0);
    chk("R10 write 0 clears flag", {31'b0, alarm_flag}, 0);

    // R2 one field off, no match
    set_now(7'h31, 7'h15, 6'h08, 1'b0, 6'h12, 3'd2);
    do_tick();
    chk("R2 sec mismatch", {31'b0, alarm_flag}, 0);
    set_now(7'h30, 7'h15, 6'h08, 1'b0, 6'h13, 3'd2);
    do_tick();
    chk("R2 date mismatch", {31'b0, alarm_flag}, 0);

    // R8 handshake timing after disable
    wr_ctl(32'h0);
    chk("R8 waf low edge 0", {31'b0, wr_allowed}, 0);
    @(negedge clk);
    chk("R8 waf low edge 1", {31'b0, wr_allowed}, (DLY <= 1) ? 1 : 0);
    @(negedge clk);
    chk("R8 waf high edge 2", {31'b0, wr_allowed}, 1);
    // R6 disabled alarm never sets
    set_now(7'h30, 7'h15, 6'h08, 1'b0, 6'h12, 3'd2);
    do_tick();
    chk("R6 disabled no flag", {31'b0, alarm_flag}, 0);

    // R3 + R4 weekday match with other fields masked, irq disabled
    wr_alm(32'h4380_8080);
    wr_ctl(32'h0000_0100);
    set_now(7'h59, 7'h42, 6'h21, 1'b0, 6'h03, 3'd3);
    do_tick();
    chk("R3 masked fields hit", {31'b0, alarm_flag}, 1);
    chk("R7 irq gated off", {31'b0, irq}, 0);
    wr_st(32'h0);
    set_now(7'h00, 7'h00, 6'h00, 1'b0, 6'h03, 3'd4);
    do_tick();
    chk("R4 wrong weekday", {31'b0, alarm_flag}, 0);
    set_now(7'h00, 7'h00, 6'h00, 1'b0, 6'h04, 3'd3);
    do_tick();
    chk("R4 weekday ignores date", {31'b0, alarm_flag}, 1);
    wr_st(32'h0);

    // R5 PM handling
    disable_and_wait();
    wr_alm(32'h8047_8000);
    wr_ctl(32'h0000_1100);
    hour12 = 1'b0;
    set_now(7'h00, 7'h33, 6'h07, 1'b0, 6'h09, 3'd1);
    do_tick();
    chk("R5 pm ignored 24h", {31'b0, alarm_flag}, 1);
    wr_st(32'h0);
    hour12 = 1'b1;
    do_tick();
    chk("R5 pm mismatch 12h", {31'b0, alarm_flag}, 0);
    cur_pm = 1'b1;
    do_tick();
    chk("R5 pm match 12h", {31'b0, alarm_flag}, 1);

    // R10 set wins over clear in same cycle
    tick = 1'b1; st_we = 1'b1; st_wdata = 32'h0;
    @(negedge clk);
    tick = 1'b0; st_we = 1'b0;
    chk("R10 set beats clear", {31'b0, alarm_flag}, 1);
    wr_st(32'h0);

    // R6 re-enable with a standing match does not set flag
    disable_and_wait();
    wr_ctl(32'h0000_1100);
    @(negedge clk);
    chk("R6 enable alone no flag", {31'b0, alarm_flag}, 0);
    do_tick();
    chk("R6 fresh match after enable", {31'b0, alarm_flag}, 1);
    hour12 = 1'b0;

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule